// File: doc/BRIEF.md
# Paired GPIO Register Bank

This block stores the byte-wide control and status registers of a 16-pin port expander. A serial bus engine in front of it has already decoded the bit protocol. It passes on transfer events (write-transfer start, read-transfer start, stop) and byte events (a received byte, a request for a byte to send). The bank turns these into register accesses. It drives a direction enable and a value for every pin, and returns read bytes that include the pin levels, each optionally inverted.

Register index `{grp[1:0], port}` selects one byte. The groups are: 0 for pin levels, 1 for the output value, 2 for read inversion, 3 for direction. The port bit selects pins 7..0 (port 0) or pins 15..8 (port 1). After each data byte the port bit flips, so a burst moves back and forth between the two ports of one group.

The controller is a three-state machine. `ST_IDLE` is the state after reset or stop, where bytes are ignored. `ST_CMD` is entered on write start, and the next received byte loads the pointer. `ST_DATA` is entered after that command byte or on read start, and there bytes are written or read. The transitions are as follows. Any state moves to `ST_IDLE` on stop, and stop has the highest priority. Any state moves to `ST_CMD` on write start. Any state moves to `ST_DATA` on read start. `ST_CMD` moves to `ST_DATA` on a received byte. `ST_DATA` stays in `ST_DATA`.

Top module: `gpio_pair_regbank`

## Requirements
- R1: A command byte selects register index `cmd[2:0]`, and the upper five bits are ignored. Indices 0/1 are pin levels, 2/3 are output values, 4/5 are inversion and 6/7 are direction, with the odd index covering pins 15..8.
- R2: The first byte received after a write start goes into the pointer only and changes no register.
- R3: Each data byte written or read in `ST_DATA` flips pointer bit 0 and keeps bits 2:1. Any number of bytes alternate between the two ports of the group.
- R4: A pin-level read returns `pin_in` whatever the direction, and writes to indices 0/1 change nothing.
- R5: An inversion bit of 1 inverts the matching pin bit in a pin-level read, and 0 passes it unchanged.
- R6: A direction bit of 1 gives `pin_oe` 0 for that pin. A direction bit of 0 gives `pin_oe` 1. `pin_out` always carries the output register.
- R7: After reset the output registers are 0xFF, the inversion registers are 0x00, the direction registers are 0xFF, the pointer is 0 and the state is `ST_IDLE`.
- R8: Reading index 2/3 returns the stored output byte, not the pin level.
- R9: A read request in `ST_DATA` puts the byte on `rd_data` with `rd_valid` high in the next cycle. Read requests in other states produce no `rd_valid`.
- R10: Bytes received in `ST_IDLE` are ignored. The pointer survives a stop, so a read transfer after a stop starts at the last pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Write transfer addressed to this bank has begun |
| start_rd | input | 1 | Read transfer addressed to this bank has begun |
| stop | input | 1 | Transfer ended |
| wr_en | input | 1 | A received byte is on `wr_byte` |
| wr_byte | input | 8 | Received byte |
| rd_en | input | 1 | Engine requests the next byte to send |
| rd_data | output | 8 | Byte to send |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| pin_in | input | 16 | Pin levels |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_out | output | 16 | Per-pin drive value |

## Verification
Every wrong pointer shows up at the ports on the very next data byte. A write lands in the wrong port or group and changes `pin_oe` or `pin_out` one cycle later. A read returns another register's byte one cycle after the request. A pointer that drifts out of its group is therefore caught within the second byte of a burst. A state error is caught at the first byte of a transfer: either a command byte is stored as data, or idle bytes take effect. Reads of the output and direction groups expose their stored values directly.

// File: rtl/gprb_pkg.sv
package gprb_pkg;
    localparam int PTR_W     = 3;
    localparam int NUM_PORTS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } bank_state_e;

    localparam logic [1:0] GRP_PIN = 2'd0;
    localparam logic [1:0] GRP_OUT = 2'd1;
    localparam logic [1:0] GRP_INV = 2'd2;
    localparam logic [1:0] GRP_DIR = 2'd3;
endpackage

// File: rtl/gprb_ctrl.sv
module gprb_ctrl
    import gprb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic             stop,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] cmd_bits,
    input  logic             rd_en,
    output logic [PTR_W-1:0] ptr,
    output logic             reg_we,
    output logic             rd_fire
);
    bank_state_e state, nxt;
    logic        xfer_ev;
    logic        cmd_load;

    assign xfer_ev = stop | start_wr | start_rd;

    always_comb begin
        nxt = state;
        if (stop)          nxt = ST_IDLE;
        else if (start_wr) nxt = ST_CMD;
        else if (start_rd) nxt = ST_DATA;
        else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_CMD:  if (wr_en) nxt = ST_DATA;
                ST_DATA: nxt = ST_DATA;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        cmd_load = 1'b0;
        reg_we   = 1'b0;
        rd_fire  = 1'b0;
        if (!xfer_ev) begin
            unique case (state)
                ST_IDLE: ;
                ST_CMD:  cmd_load = wr_en;
                ST_DATA: begin
                    reg_we  = wr_en;
                    rd_fire = rd_en & ~wr_en;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ptr <= '0;
        else if (cmd_load)          ptr <= cmd_bits;
        else if (reg_we || rd_fire) ptr <= {ptr[PTR_W-1:1], ~ptr[0]};
    end

    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || rd_fire) |=> (ptr[0] != $past(ptr[0])) && (ptr[2:1] == $past(ptr[2:1])));
    // R3
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> $stable(ptr[2:1]));
    // R2
    cmd_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (state == ST_DATA) && (ptr == $past(cmd_bits)));
endmodule

// File: rtl/gprb_regfile.sv
module gprb_regfile
    import gprb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [PTR_W-1:0]            idx,
    input  logic [PORT_W-1:0]           wdata,
    output logic [NUM_PORTS*PORT_W-1:0] out_q,
    output logic [NUM_PORTS*PORT_W-1:0] inv_q,
    output logic [NUM_PORTS*PORT_W-1:0] dir_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel = we && (idx[0] == p[0]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[p*PORT_W +: PORT_W] <= '1;
                inv_q[p*PORT_W +: PORT_W] <= '0;
                dir_q[p*PORT_W +: PORT_W] <= '1;
            end else if (sel) begin
                unique case (idx[2:1])
                    GRP_OUT: out_q[p*PORT_W +: PORT_W] <= wdata;
                    GRP_INV: inv_q[p*PORT_W +: PORT_W] <= wdata;
                    GRP_DIR: dir_q[p*PORT_W +: PORT_W] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // R4
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx[2:1] == GRP_PIN) |=> $stable(out_q) && $stable(inv_q) && $stable(dir_q));
endmodule

// File: rtl/gprb_rdmux.sv
module gprb_rdmux
    import gprb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [PTR_W-1:0]            idx,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_lvl,
    input  logic [NUM_PORTS*PORT_W-1:0] out_q,
    input  logic [NUM_PORTS*PORT_W-1:0] inv_q,
    input  logic [NUM_PORTS*PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0]           rbyte
);
    logic [PORT_W-1:0] lvl_b, out_b, inv_b, dir_b;

    assign lvl_b = pin_lvl[idx[0]*PORT_W +: PORT_W];
    assign out_b = out_q[idx[0]*PORT_W +: PORT_W];
    assign inv_b = inv_q[idx[0]*PORT_W +: PORT_W];
    assign dir_b = dir_q[idx[0]*PORT_W +: PORT_W];

    always_comb begin
        unique case (idx[2:1])
            GRP_PIN: rbyte = lvl_b ^ inv_b;
            GRP_OUT: rbyte = out_b;
            GRP_INV: rbyte = inv_b;
            default: rbyte = dir_b;
        endcase
    end
endmodule

// File: rtl/gpio_pair_regbank.sv
module gpio_pair_regbank
    import gprb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_wr,
    input  logic                        start_rd,
    input  logic                        stop,
    input  logic                        wr_en,
    input  logic [PORT_W-1:0]           wr_byte,
    input  logic                        rd_en,
    output logic [PORT_W-1:0]           rd_data,
    output logic                        rd_valid,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out
);
    localparam int PIN_N = NUM_PORTS * PORT_W;

    logic [PTR_W-1:0]  ptr;
    logic              reg_we, rd_fire;
    logic [PIN_N-1:0]  out_q, inv_q, dir_q;
    logic [PORT_W-1:0] rbyte;

    gprb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .stop     (stop),
        .wr_en    (wr_en),
        .cmd_bits (wr_byte[PTR_W-1:0]),
        .rd_en    (rd_en),
        .ptr      (ptr),
        .reg_we   (reg_we),
        .rd_fire  (rd_fire)
    );

    gprb_regfile #(.PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (ptr),
        .wdata (wr_byte),
        .out_q (out_q),
        .inv_q (inv_q),
        .dir_q (dir_q)
    );

    gprb_rdmux #(.PORT_W(PORT_W)) u_rmux (
        .idx     (ptr),
        .pin_lvl (pin_in),
        .out_q   (out_q),
        .inv_q   (inv_q),
        .dir_q   (dir_q),
        .rbyte   (rbyte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= rbyte;
        end
    end

    assign pin_oe  = ~dir_q;
    assign pin_out = out_q;

    // R9
    rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));
    // R6
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe == '0) && !(reg_we && ptr[2:1] == GRP_DIR)) |=> (pin_oe == '0));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start_wr && !start_rd) |=> !rd_valid);
endmodule

// File: tb/gpio_pair_regbank_test.sv
module gpio_pair_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 0, start_rd = 0, stop = 0, wr_en = 0, rd_en = 0;
    logic [7:0]  wr_byte = 0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_oe, pin_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_out = 16'hFFFF, m_inv = 16'h0000, m_dir = 16'hFFFF;
    logic [2:0]  m_ptr = 3'd0;
    int          m_st = 0; // 0 idle, 1 command, 2 data
    logic [7:0]  expq[$];
    string       tagq[$];

    always #5 clk = ~clk;

    gpio_pair_regbank uut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .stop(stop), .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(logic [2:0] p);
        logic [15:0] v;
        case (p[2:1])
            2'd0: v = pin_in ^ m_inv;
            2'd1: v = m_out;
            2'd2: v = m_inv;
            default: v = m_dir;
        endcase
        return p[0] ? v[15:8] : v[7:0];
    endfunction

    task automatic pulse_wr_start;
        m_st = 1;
        @(negedge clk) start_wr = 1;
        @(negedge clk) start_wr = 0;
    endtask

    task automatic pulse_rd_start;
        m_st = 2;
        @(negedge clk) start_rd = 1;
        @(negedge clk) start_rd = 0;
    endtask

    task automatic pulse_stop;
        m_st = 0;
        @(negedge clk) stop = 1;
        @(negedge clk) stop = 0;
    endtask

    task automatic send(logic [7:0] b);
        if (m_st == 1) begin
            m_ptr = b[2:0];
            m_st  = 2;
        end else if (m_st == 2) begin
            case (m_ptr[2:1])
                2'd1: if (m_ptr[0]) m_out[15:8] = b; else m_out[7:0] = b;
                2'd2: if (m_ptr[0]) m_inv[15:8] = b; else m_inv[7:0] = b;
                2'd3: if (m_ptr[0]) m_dir[15:8] = b; else m_dir[7:0] = b;
                default: ;
            endcase
            m_ptr[0] = ~m_ptr[0];
        end
        @(negedge clk) begin wr_en = 1; wr_byte = b; end
        @(negedge clk) wr_en = 0;
    endtask

    task automatic fetch(string tag);
        if (m_st == 2) begin
            expq.push_back(exp_byte(m_ptr));
            tagq.push_back(tag);
            m_ptr[0] = ~m_ptr[0];
        end
        @(negedge clk) rd_en = 1;
        @(negedge clk) rd_en = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected read byte %h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        pin_in = 16'hC3A5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7 reset state
        check16("R7 pin_oe", pin_oe, 16'h0000);
        check16("R7 pin_out", pin_out, 16'hFFFF);
        // R7 pointer 0, R4 pin read
        pulse_rd_start;
        fetch("R7 R4 ptr0 read");
        fetch("R3 R4 read port1");

        // R6 direction write, R3 alternation
        pulse_wr_start;
        send(8'h06);
        send(8'h0F);
        send(8'hF0);
        pulse_stop;
        check16("R6 pin_oe", pin_oe, 16'h0FF0);

        // R3 unlimited burst on outputs starting at port 1
        pulse_wr_start;
        send(8'h03);
        send(8'h12);
        send(8'h34);
        send(8'h56);
        pulse_stop;
        check16("R3 R6 pin_out", pin_out, 16'h5634);

        // R8 output read differs from pins, R10 pointer kept across stop
        pin_in = 16'h0000;
        pulse_wr_start;
        send(8'h02);
        pulse_stop;
        // R2: command byte alone must not change outputs
        check16("R2 pin_out", pin_out, 16'h5634);
        pulse_rd_start;
        fetch("R8 R10 read out0");
        fetch("R8 read out1");
        fetch("R3 read out0 again");
        pulse_stop;

        // R1 masked command, R5 inversion
        pulse_wr_start;
        send(8'hED);
        send(8'hFF);
        send(8'h0F);
        pin_in = 16'hA55A;
        pulse_wr_start;
        send(8'hF8);
        pulse_rd_start;
        fetch("R5 R1 pin0 inverted");
        fetch("R5 pin1 inverted");
        pulse_stop;

        // R4 writes to pin registers ignored
        pulse_wr_start;
        send(8'h01);
        send(8'h00);
        send(8'h00);
        pulse_stop;
        check16("R4 pin_out", pin_out, 16'h5634);
        check16("R4 pin_oe", pin_oe, 16'h0FF0);
        pulse_wr_start;
        send(8'h04);
        pulse_rd_start;
        fetch("R4 inv0 readback");
        fetch("R4 inv1 readback");

        // R10 idle bytes ignored, reads in idle silent
        pulse_stop;
        send(8'h00);
        send(8'h07);
        fetch("R9 idle read");
        check16("R10 pin_out", pin_out, 16'h5634);
        check16("R10 pin_oe", pin_oe, 16'h0FF0);

        // R1 direction group readback via masked command
        pulse_wr_start;
        send(8'h7E);
        pulse_rd_start;
        fetch("R1 dir0 read");
        fetch("R1 dir1 read");
        pulse_stop;

        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R9: actual %0d pending expected 0", expq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule